// File: doc/BRIEF.md
# Reset Controller with Cause Register

This block gathers five reset requests (a power-on indication, an active-low external reset pin, a brown-out detect, a watchdog request and a software request) and merges them into one system reset for the core and the peripherals. Any active request pulls the system reset low at once, without waiting for a clock edge. Release is synchronised to the clock and then held for a programmable number of extra cycles, so that every domain leaves reset cleanly. A second reset output for the debug port follows only the power-on indication. A debug session therefore survives every other kind of reset.

Alongside the reset outputs, the block keeps a cause register that records which sources have fired. Each bit stays set through later resets from other sources, so several bits can be set at once. Only a power-on event wipes the record, and it leaves only its own bit set. Software reads the register through a plain read/write port and clears a bit by writing a zero to it.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `por_req_i`, `bor_req_i` or `wdt_req_i` is high, or `pin_rst_n_i` is low, `sys_rst_n_o` is low, with no dependence on any clock edge.
- R2: A `sw_req_i` pulse sampled high at one rising edge is held internally, so `sys_rst_n_o` is low from that edge on. The held request clears at the first later edge at which `sys_rst_n_o` is already low.
- R3: `sys_rst_n_o` goes high at the 18th rising edge (SYNC_STAGES 2 plus STRETCH 16) counted from the first edge at which every source is inactive and no software request is held.
- R4: `dbg_rst_n_o` is low while `por_req_i` is high. It goes high at the 2nd rising edge after `por_req_i` falls. The pin, brown-out, watchdog and software sources never change it.
- R5: The cause read on `reg_rdata_o` uses this layout: bit 0 pin, bit 1 power-on, bit 2 brown-out, bit 3 watchdog, bit 4 software. Bits 7:5 always read zero, and the read is combinational.
- R6: While `por_req_i` is high, the cause register reads 0x02, and the read stays 0x02 until a new event or a write.
- R7: A watchdog request sets bit 3 at the edge where it is sampled high. A held software request sets bit 4 at the edge after the pulse. Pin and brown-out requests set bits 0 and 2 two edges after the edge where they are first sampled, because they pass through a synchroniser.
- R8: Cause bits are sticky. Pin, brown-out, watchdog and software resets never clear any bit.
- R9: When `reg_wr_i` is high at an edge, every cause bit whose `reg_wdata_i` bit is 0 is cleared. Bits written with 1 keep their value.
- R10: If a source event and a clearing write hit the same cause bit at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_req_i | input | 1 | Power-on reset indication, active high, asynchronous |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| bor_req_i | input | 1 | Brown-out detect, active high, asynchronous |
| wdt_req_i | input | 1 | Watchdog reset request, active high, synchronous to clk |
| sw_req_i | input | 1 | Software reset request pulse, synchronous to clk |
| reg_wr_i | input | 1 | Write strobe for the cause register |
| reg_wdata_i | input | 5 | Write data; a 0 clears the matching cause bit |
| reg_rdata_o | output | DATA_W | Cause register read value |
| sys_rst_n_o | output | 1 | Core and peripheral reset, active low |
| dbg_rst_n_o | output | 1 | Debug-port reset, active low |

## Verification
The properties assume that every request input except `por_req_i` changes only away from the rising clock edge. They also assume that a power-on pulse lasts at least one full clock period, so that its disable window covers the async reset it causes. The stretch check counts quiet cycles in the checker, so it assumes the pin and brown-out inputs do not glitch shorter than a cycle. The bench meets all of this by driving every input on the falling edge and by holding each request for one or more whole cycles. It also issues a software request while a watchdog reset is already active, and a clearing write in the same cycle as a watchdog event.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int NUM_SRC = 5;
    localparam int BIT_PIN = 0;
    localparam int BIT_POR = 1;
    localparam int BIT_BOR = 2;
    localparam int BIT_WDT = 3;
    localparam int BIT_SW  = 4;

    typedef logic [NUM_SRC-1:0] cause_t;

    localparam cause_t POR_ONLY = cause_t'(1 << BIT_POR);
endpackage

// File: rtl/rstc_sync.sv
// Multi-stage synchroniser with asynchronous reset to a chosen level.
module rstc_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        for (int i = STAGES - 1; i > 0; i--) begin
            sync_d.sh[i] = sync_q.sh[i-1];
        end
        sync_d.sh[0] = din;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            sync_q <= '{sh: {STAGES{RST_VAL}}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.sh[STAGES-1];
endmodule

// File: rtl/rstc_release.sv
// Async assertion, synchronised release, then a stretch of STRETCH cycles.
module rstc_release #(
    parameter int STAGES  = 2,
    parameter int STRETCH = 16
) (
    input  logic clk,
    input  logic arst,
    output logic rst_n
);
    localparam int CNT_W = $clog2(STRETCH + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rel;
    } rel_st_t;

    rel_st_t rel_d, rel_q;
    logic    sync_ok;

    rstc_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
        .clk  (clk),
        .arst (arst),
        .din  (1'b1),
        .dout (sync_ok)
    );

    always_comb begin
        rel_d = rel_q;
        if (sync_ok && !rel_q.rel) begin
            rel_d.cnt = rel_q.cnt + 1'b1;
            if (rel_q.cnt == CNT_W'(STRETCH - 1)) begin
                rel_d.rel = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            rel_q <= '0;
        end else begin
            rel_q <= rel_d;
        end
    end

    assign rst_n = rel_q.rel;
endmodule

// File: rtl/rstc_cause.sv
// Sticky cause record, reset only by power-on; write-zero-to-clear.
module rstc_cause
    import rstc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              por,
    input  cause_t            ev,
    input  logic              wr,
    input  cause_t            wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        cause_t cause;
    } cause_st_t;

    cause_st_t cz_d, cz_q;

    always_comb begin
        cz_d = cz_q;
        if (wr) begin
            cz_d.cause = cz_q.cause & wdata;
        end
        // events override a clear in the same cycle
        cz_d.cause = cz_d.cause | ev;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            cz_q <= '{cause: POR_ONLY};
        end else begin
            cz_q <= cz_d;
        end
    end

    assign rdata = DATA_W'(cz_q.cause);
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH     = 16,
    parameter int DATA_W      = 8
) (
    input  logic               clk,
    input  logic               por_req_i,
    input  logic               pin_rst_n_i,
    input  logic               bor_req_i,
    input  logic               wdt_req_i,
    input  logic               sw_req_i,
    input  logic               reg_wr_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               sys_rst_n_o,
    output logic               dbg_rst_n_o
);
    localparam int N_ASYNC = 2;
    localparam int A_PIN   = 0;
    localparam int A_BOR   = 1;

    typedef struct packed {
        logic sw_pend;
    } top_st_t;

    top_st_t            top_d, top_q;
    logic               sw_pend;
    logic               sys_arst;
    logic [N_ASYNC-1:0] async_raw;
    logic [N_ASYNC-1:0] async_sync;
    cause_t             events;

    // software request is held until the system reset is seen asserted
    always_comb begin
        top_d = top_q;
        if (sw_req_i) begin
            top_d.sw_pend = 1'b1;
        end else if (!sys_rst_n_o) begin
            top_d.sw_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge por_req_i) begin
        if (por_req_i) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign sw_pend  = top_q.sw_pend;
    assign sys_arst = por_req_i | ~pin_rst_n_i | bor_req_i | wdt_req_i | sw_pend;

    // asynchronous sources are synchronised before being recorded
    assign async_raw[A_PIN] = ~pin_rst_n_i;
    assign async_raw[A_BOR] = bor_req_i;

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_async
        rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
            .clk  (clk),
            .arst (por_req_i),
            .din  (async_raw[g]),
            .dout (async_sync[g])
        );
    end

    always_comb begin
        events          = '0;
        events[BIT_PIN] = async_sync[A_PIN];
        events[BIT_BOR] = async_sync[A_BOR];
        events[BIT_WDT] = wdt_req_i;
        events[BIT_SW]  = sw_pend;
    end

    rstc_release #(.STAGES(SYNC_STAGES), .STRETCH(STRETCH)) u_release (
        .clk   (clk),
        .arst  (sys_arst),
        .rst_n (sys_rst_n_o)
    );

    rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dbg (
        .clk  (clk),
        .arst (por_req_i),
        .din  (1'b1),
        .dout (dbg_rst_n_o)
    );

    rstc_cause #(.DATA_W(DATA_W)) u_cause (
        .clk   (clk),
        .por   (por_req_i),
        .ev    (events),
        .wr    (reg_wr_i),
        .wdata (reg_wdata_i),
        .rdata (reg_rdata_o)
    );
endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk
    import rstc_pkg::*;
#(
    parameter int STRETCH = 16,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               por_req_i,
    input logic               pin_rst_n_i,
    input logic               bor_req_i,
    input logic               wdt_req_i,
    input logic               sw_req_i,
    input logic               sw_pend,
    input logic               reg_wr_i,
    input logic [NUM_SRC-1:0] reg_wdata_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               sys_rst_n_o,
    input logic               dbg_rst_n_o
);
    logic [15:0] quiet_cnt;
    logic        src_on;

    assign src_on = !pin_rst_n_i || bor_req_i || wdt_req_i || sw_pend;

    always_ff @(posedge clk or posedge por_req_i) begin
        if (por_req_i) begin
            quiet_cnt <= '0;
        end else if (src_on) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != 16'hffff) begin
            quiet_cnt <= quiet_cnt + 16'd1;
        end
    end

    // R1
    a_r1_async_assert: assert property (@(posedge clk) disable iff (por_req_i)
        (!pin_rst_n_i || bor_req_i || wdt_req_i) |-> !sys_rst_n_o);

    // R2
    a_r2_sw_held: assert property (@(posedge clk) disable iff (por_req_i)
        sw_req_i |=> !sys_rst_n_o);

    // R3
    a_r3_min_stretch: assert property (@(posedge clk) disable iff (por_req_i)
        $rose(sys_rst_n_o) |-> (quiet_cnt >= 16'(STRETCH)));

    // R4
    a_r4_dbg_only_por: assert property (@(posedge clk) disable iff (por_req_i)
        dbg_rst_n_o |=> dbg_rst_n_o);

    // R5
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (por_req_i)
        reg_rdata_o[DATA_W-1:NUM_SRC] == '0);

    // R6
    a_r6_por_only: assert property (@(posedge clk) disable iff (por_req_i)
        $fell(por_req_i) |-> (reg_rdata_o == DATA_W'(POR_ONLY)));

    // R8
    a_r8_sticky: assert property (@(posedge clk) disable iff (por_req_i)
        !reg_wr_i |=> ((reg_rdata_o & $past(reg_rdata_o)) == $past(reg_rdata_o)));

    // R9
    a_r9_ones_keep: assert property (@(posedge clk) disable iff (por_req_i)
        reg_wr_i |=> ((reg_rdata_o[NUM_SRC-1:0] & $past(reg_wdata_i & reg_rdata_o[NUM_SRC-1:0]))
                      == $past(reg_wdata_i & reg_rdata_o[NUM_SRC-1:0])));

    // R10
    a_r10_event_wins: assert property (@(posedge clk) disable iff (por_req_i)
        wdt_req_i |=> reg_rdata_o[BIT_WDT]);
endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk #(.STRETCH(STRETCH), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .por_req_i   (por_req_i),
    .pin_rst_n_i (pin_rst_n_i),
    .bor_req_i   (bor_req_i),
    .wdt_req_i   (wdt_req_i),
    .sw_req_i    (sw_req_i),
    .sw_pend     (sw_pend),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .sys_rst_n_o (sys_rst_n_o),
    .dbg_rst_n_o (dbg_rst_n_o)
);

// File: tb/reset_cause_ctrl_test.sv
module reset_cause_ctrl_test;
    localparam int STAGES  = 2;
    localparam int STRETCH = 16;
    localparam int DW      = 8;
    localparam int REL     = STAGES + STRETCH;

    logic       clk = 1'b0;
    logic       por, pin_n, bor, wdt, sw, wr;
    logic [4:0] wdata;
    logic [DW-1:0] rdata;
    logic       sys_n, dbg_n;

    always #4 clk = ~clk;

    reset_cause_ctrl #(.SYNC_STAGES(STAGES), .STRETCH(STRETCH), .DATA_W(DW)) uut (
        .clk         (clk),
        .por_req_i   (por),
        .pin_rst_n_i (pin_n),
        .bor_req_i   (bor),
        .wdt_req_i   (wdt),
        .sw_req_i    (sw),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .sys_rst_n_o (sys_n),
        .dbg_rst_n_o (dbg_n)
    );

    // behavioural reference state
    int       checks = 0;
    int       fails  = 0;
    int       quiet  = 0;
    int       dquiet = 0;
    bit       sw_pend_m = 1'b0;
    bit [4:0] cause_m = 5'h00;
    bit       pin_hist[$];
    bit       bor_hist[$];
    bit       exp_sys = 1'b0;
    bit       exp_dbg = 1'b0;
    string    req = "R6";

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit ev_pin, ev_bor, busy;
        if (por) begin
            cause_m   = 5'h02;
            sw_pend_m = 1'b0;
            quiet     = 0;
            dquiet    = 0;
            pin_hist.delete();
            bor_hist.delete();
            repeat (STAGES) begin
                pin_hist.push_back(1'b0);
                bor_hist.push_back(1'b0);
            end
        end else begin
            dquiet++;
            busy = !pin_n || bor || wdt || sw_pend_m;
            if (busy) quiet = 0;
            else quiet++;
            ev_pin = pin_hist.pop_front();
            ev_bor = bor_hist.pop_front();
            pin_hist.push_back(!pin_n);
            bor_hist.push_back(bor);
            cause_m = (cause_m & (wr ? wdata : 5'h1f)) | {sw_pend_m, wdt, ev_bor, 1'b0, ev_pin};
            if (sw) sw_pend_m = 1'b1;
            else if (!exp_sys) sw_pend_m = 1'b0;
            if (sw_pend_m) quiet = 0;
        end
        exp_sys = !por && (quiet >= REL) && !(!pin_n || bor || wdt || sw_pend_m);
        exp_dbg = !por && (dquiet >= STAGES);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("sys_rst_n", int'(sys_n), int'(exp_sys));
        check("dbg_rst_n", int'(dbg_n), int'(exp_dbg));
        check("cause", int'(rdata), int'({3'b000, cause_m}));
    endtask

    task automatic run(int n);
        repeat (n) step();
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        por = 1'b0; pin_n = 1'b1; bor = 1'b0; wdt = 1'b0; sw = 1'b0;
        wr = 1'b0; wdata = 5'h1f;
        repeat (STAGES) begin
            pin_hist.push_back(1'b0);
            bor_hist.push_back(1'b0);
        end
        #1 por = 1'b1;
        // R6: power-on state
        req = "R6"; run(3);
        @(negedge clk);
        por = 1'b0;
        req = "R4"; run(2);
        req = "R3"; run(24);
        // R5: upper bits read zero
        req = "R5"; check("upper bits", int'(rdata[7:5]), 0);

        // R1 watchdog, R7 recording latency
        req = "R1"; wdt = 1'b1; run(2); wdt = 1'b0;
        req = "R3"; run(22);

        // R7 pin: debug reset untouched (R4)
        req = "R7"; pin_n = 1'b0; run(3); pin_n = 1'b1;
        req = "R4"; run(22);

        // R7 brown-out
        req = "R7"; bor = 1'b1; run(2); bor = 1'b0; run(22);

        // R2 software pulse, R8 all bits retained
        req = "R2"; sw = 1'b1; run(1); sw = 1'b0;
        req = "R8"; run(22);
        check("all sticky", int'(rdata), 8'h1f);

        // R9 write zero clears, write one keeps
        req = "R9"; wr = 1'b1; wdata = 5'b11110; run(1);
        wr = 1'b0; run(2);
        wr = 1'b1; wdata = 5'h1f; run(1);
        wr = 1'b0; run(1);
        check("after keep write", int'(rdata), 8'h1e);

        // R10 event wins over clear in the same cycle
        req = "R10"; wr = 1'b1; wdata = 5'h00; wdt = 1'b1; run(1);
        wr = 1'b0; wdt = 1'b0; run(22);
        check("event wins", int'(rdata), 8'h08);

        // R2 software request while already in reset
        req = "R2"; wdt = 1'b1; run(2); sw = 1'b1; run(1); sw = 1'b0; wdt = 1'b0;
        run(24);

        // R6 second power-on wipes other bits
        req = "R6"; por = 1'b1; run(2);
        @(negedge clk);
        por = 1'b0; run(1);
        check("por only", int'(rdata), 8'h02);
        req = "R3"; run(20);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule